// File: doc/BRIEF.md
# Saturating Popcount Accumulator

This block sums neighbour bits for a cellular-automaton update engine that runs at display scan rate. On each enabled clock edge it takes a group of three single-bit inputs and counts how many of them are high. It adds that count to a 3-bit running total. The total never wraps. It stops at a clamp value, `SAT_MAX`, which is chosen when the block is built.

A 3:2 compressor (a full adder) reduces the three bits to a 2-bit count. A bounded adder then combines the count with the stored total. When any sum bit at or above the clamp threshold is set, the result is forced to `SAT_MAX`. When the stored total is already at `SAT_MAX`, the new bits are bypassed.

The counting and the bounded add sit on one combinational path, so the block takes a new group every clock. A synchronous clear starts a fresh cell. The `satd` flag tells the next-state rule that the clamp has been reached.

Top module: `sat_popcount_acc`

## Requirements
- R1: When `clr` is high on a rising edge, `count` is 0 after that edge, whatever `en` and `nbrBits` are; `clr` takes priority over `en`.
- R2: When `clr` and `en` are both low on a rising edge, `count` keeps its value, whatever `nbrBits` are.
- R3: The count of a group is the number of high bits in `nbrBits`: 0, 1, 2 or 3. Starting from 0, one enabled step leaves `count` equal to that number.
- R4: On an enabled edge with `clr` low, the new `count` is the old `count` plus the group's count, limited to `SAT_MAX`.
- R5: With `SAT_MAX` = 7, the total never wraps. For example, 3+3 gives 6, and 4+3, 5+3, 6+3 and 7+3 all give 7.
- R6: With `SAT_MAX` = 4, `count` stays in the range 0 to 4, and every true sum above 4 gives exactly 4.
- R7: `satd` is 1 exactly when `count` equals `SAT_MAX`.
- R8: Once `count` equals `SAT_MAX`, further enabled steps leave it at `SAT_MAX` for every input pattern.
- R9: Enabled groups on consecutive clock cycles are each added, with no idle cycle between them.
- R10: `SAT_MAX` accepts only the values 4 and 7. Any other value stops elaboration with an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| clr | input | 1 | Synchronous clear of the running total |
| en | input | 1 | Step strobe: add the current group |
| nbrBits | input | 3 | The three neighbour bits of this group |
| count | output | 3 | Running clamped total |
| satd | output | 1 | High while `count` equals `SAT_MAX` |

## Verification
Every input change lands on the next rising edge, because the only register is the accumulator. So `count` and `satd` are due one edge after the step that set them. The bench drives each step on a falling edge and waits through one rising edge. It then compares both outputs at the following falling edge, against a model that adds the bench's own bit count and clamps it. Two copies of the block, clamped at 7 and at 4, see the same stimulus: every start value from 0 to 7, followed by each of the eight input patterns. Idle cycles with toggling bits are checked in the same cycle-by-cycle way.

// File: rtl/pc_pkg.sv
package pc_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearAcc;
    logic loadAcc;
  } ctrlStrobe_t;

endpackage

// File: rtl/pc_compress3.sv
// 3:2 compressor: sum bit is the parity of the inputs, carry bit the majority
module pc_compress3 (
  input  logic [2:0] inBits,
  output logic [1:0] onesCnt
);
  logic sumBit;
  logic carryBit;

  always_comb begin
    sumBit   = inBits[0] ^ inBits[1] ^ inBits[2];
    carryBit = (inBits[0] & inBits[1]) | (inBits[0] & inBits[2]) | (inBits[1] & inBits[2]);
    onesCnt  = {carryBit, sumBit};
  end
endmodule

// File: rtl/pc_ctrl.sv
module pc_ctrl
  import pc_pkg::*;
(
  input  logic        clr,
  input  logic        en,
  output ctrlStrobe_t strobes
);
  always_comb begin
    strobes.clearAcc = clr;
    strobes.loadAcc  = en & ~clr;
  end
endmodule

// File: rtl/pc_datapath.sv
module pc_datapath
  import pc_pkg::*;
#(
  parameter int SAT_MAX = 7,
  parameter int ACC_W   = 3
) (
  input  logic             clk,
  input  ctrlStrobe_t      strobes,
  input  logic [2:0]       nbrBits,
  output logic [ACC_W-1:0] accValue,
  output logic             satFlag
);
  localparam int SUM_W   = ACC_W + 1;
  // lowest sum bit that, when set, means the clamp is reached
  localparam int SAT_BIT = (SAT_MAX == 4) ? 2 : ACC_W;
  localparam logic [ACC_W-1:0] MAX_VAL = ACC_W'(SAT_MAX);

  logic [1:0]       onesCnt;
  logic [SUM_W-1:0] sumFull;
  logic             overHit;
  logic             atMax;
  logic [ACC_W-1:0] nextVal;
  logic [ACC_W-1:0] accReg;

  pc_compress3 i_compress (
    .inBits  (nbrBits),
    .onesCnt (onesCnt)
  );

  always_comb begin
    atMax   = (accReg == MAX_VAL);
    sumFull = {1'b0, accReg} + SUM_W'(onesCnt);
    overHit = |sumFull[SUM_W-1:SAT_BIT];
    if (atMax || overHit) begin
      nextVal = MAX_VAL;
    end else begin
      nextVal = sumFull[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.clearAcc) begin
      accReg <= '0;
    end else if (strobes.loadAcc) begin
      accReg <= nextVal;
    end
  end

  assign accValue = accReg;
  assign satFlag  = atMax;
endmodule

// File: rtl/sat_popcount_acc.sv
module sat_popcount_acc
  import pc_pkg::*;
#(
  parameter int SAT_MAX = 7
) (
  input  logic       clk,
  input  logic       clr,
  input  logic       en,
  input  logic [2:0] nbrBits,
  output logic [2:0] count,
  output logic       satd
);
  localparam int ACC_W = 3;

  generate
    if (SAT_MAX != 4 && SAT_MAX != 7) begin : g_badMax
      $error("sat_popcount_acc: SAT_MAX must be 4 or 7");  // R10
    end
  endgenerate

  ctrlStrobe_t strobes;

  pc_ctrl i_ctrl (
    .clr     (clr),
    .en      (en),
    .strobes (strobes)
  );

  pc_datapath #(
    .SAT_MAX (SAT_MAX),
    .ACC_W   (ACC_W)
  ) i_datapath (
    .clk      (clk),
    .strobes  (strobes),
    .nbrBits  (nbrBits),
    .accValue (count),
    .satFlag  (satd)
  );
endmodule

// File: rtl/sat_popcount_acc_chk.sv
module sat_popcount_acc_chk #(
  parameter int SAT_MAX = 7
) (
  input logic       clk,
  input logic       clr,
  input logic       en,
  input logic [2:0] nbrBits,
  input logic [2:0] count,
  input logic       satd
);
  localparam logic [2:0] MAX_VAL = 3'(SAT_MAX);

  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (clr) armed <= 1'b1;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!armed)
    clr |=> (count == 3'd0)) else $error("clear failed");  // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!armed)
    (!clr && !en) |=> $stable(count)) else $error("hold failed");  // R2

  AST_NO_DECREASE: assert property (@(posedge clk) disable iff (!armed)
    (!clr && en) |=> (count >= $past(count))) else $error("step decreased");  // R4

  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!armed)
    (!clr && en) |=> ((count - $past(count)) <= 3'd3)) else $error("step too large");  // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!armed || clr)
    count <= MAX_VAL) else $error("above clamp");  // R6

  AST_SAT_FLAG: assert property (@(posedge clk) disable iff (!armed || clr)
    satd == (count == MAX_VAL)) else $error("flag mismatch");  // R7

  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!armed)
    (satd && en && !clr) |=> (count == MAX_VAL)) else $error("left clamp");  // R8
endmodule

bind sat_popcount_acc sat_popcount_acc_chk #(.SAT_MAX(SAT_MAX)) i_chk (
  .clk     (clk),
  .clr     (clr),
  .en      (en),
  .nbrBits (nbrBits),
  .count   (count),
  .satd    (satd)
);

// File: tb/test_sat_popcount_acc.sv
`timescale 1ns/1ps
module test_sat_popcount_acc;
  logic       clk = 1'b0;
  logic       clr = 1'b0;
  logic       en  = 1'b0;
  logic [2:0] nbrBits = 3'd0;
  logic [2:0] cnt7, cnt4;
  logic       sat7, sat4;

  int errors = 0;
  int checks = 0;
  int m7 = 0;
  int m4 = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  sat_popcount_acc #(.SAT_MAX(7)) i_sat_popcount_acc (
    .clk(clk), .clr(clr), .en(en), .nbrBits(nbrBits), .count(cnt7), .satd(sat7));

  sat_popcount_acc #(.SAT_MAX(4)) i_sat_popcount_acc4 (
    .clk(clk), .clr(clr), .en(en), .nbrBits(nbrBits), .count(cnt4), .satd(sat4));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int clampAdd(input int a, input int b, input int mx);
    return (a + b > mx) ? mx : a + b;
  endfunction

  // drive at a falling edge, let one rising edge pass, check at the next falling edge
  task automatic doStep(input logic c, input logic e, input logic [2:0] b,
                        input string tag7, input string tag4);
    int pc;
    clr = c; en = e; nbrBits = b;
    pc = int'(b[0]) + int'(b[1]) + int'(b[2]);
    @(posedge clk);
    if (c) begin
      m7 = 0; m4 = 0;
    end else if (e) begin
      m7 = clampAdd(m7, pc, 7);
      m4 = clampAdd(m4, pc, 4);
    end
    @(negedge clk);
    chk(tag7, int'(cnt7), m7);
    chk(tag4, int'(cnt4), m4);
    chk("R7 flag7", int'(sat7), int'(m7 == 7));
    chk("R7 flag4", int'(sat4), int'(m4 == 4));
    checks++;
    if (cnt4 > 3'd4) begin
      errors++;
      $display("FAIL R6 actual=%0d expected<=4", cnt4);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    string t7, t4;
    int pc;
    @(negedge clk);
    // reset state, with clr beating en (R1)
    doStep(1'b1, 1'b1, 3'b111, "R1 clr7", "R1 clr4");

    // single-step popcount from zero for all patterns (R3)
    for (int p = 0; p < 8; p++) begin
      doStep(1'b1, 1'b0, 3'b000, "R1", "R1");
      doStep(1'b0, 1'b1, 3'(p), "R3 pop7", "R3 pop4");
    end

    // exhaustive: every start value then every pattern
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < 8; p++) begin
        doStep(1'b1, 1'b0, 3'b000, "R1", "R1");
        for (int k = 0; k < s; k++) begin
          doStep(1'b0, 1'b1, 3'b010, "R9 ramp7", "R9 ramp4");
        end
        pc = int'(p[0]) + int'(p[1]) + int'(p[2]);
        if (m7 == 7) t7 = "R8 stick7";
        else if (m7 + pc > 7) t7 = "R5 bound7";
        else t7 = "R4 add7";
        if (m4 == 4) t4 = "R8 stick4";
        else if (m4 + pc > 4) t4 = "R6 bound4";
        else t4 = "R4 add4";
        doStep(1'b0, 1'b1, 3'(p), t7, t4);
        // idle cycles with changing bits must not move the total (R2)
        doStep(1'b0, 1'b0, 3'b111, "R2 hold7", "R2 hold4");
        doStep(1'b0, 1'b0, 3'(p), "R2 hold7", "R2 hold4");
      end
    end

    // named cases from the clamp-at-7 list (R5)
    doStep(1'b1, 1'b0, 3'b000, "R1", "R1");
    doStep(1'b0, 1'b1, 3'b111, "R9 back7", "R9 back4");
    doStep(1'b0, 1'b1, 3'b111, "R5 3+3", "R6 3+3");
    doStep(1'b0, 1'b1, 3'b111, "R5 6+3", "R8 4+3");

    // consecutive mixed steps, one per cycle (R9)
    doStep(1'b1, 1'b0, 3'b000, "R1", "R1");
    doStep(1'b0, 1'b1, 3'b001, "R9 seq7", "R9 seq4");
    doStep(1'b0, 1'b1, 3'b000, "R9 seq7", "R9 seq4");
    doStep(1'b0, 1'b1, 3'b110, "R9 seq7", "R9 seq4");
    doStep(1'b0, 1'b1, 3'b101, "R9 seq7", "R9 seq4");
    doStep(1'b0, 1'b1, 3'b011, "R9 seq7", "R9 seq4");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule